// File: doc/BRIEF.md
# Nested Interrupt Status Controller

This block keeps the interrupt nesting level of a small 4-bit processor core and decides, every cycle, whether one of its pending interrupt sources may be taken. Each source latches a request pulse into a pending flag, has its own enable bit and carries a high/low priority attribute. A single master enable gates all acceptance. When a source is taken, the block pushes the complete 8-bit status word onto the core's stack interface, raises the nesting level by one and reloads the two bank-enable flags from the top bits of that source's vector byte.

A return-from-interrupt strobe brings back a saved status word: the level and both bank-enable flags are reloaded inside the block, while the carry and skip bits are handed back to the core on restore outputs. Subroutine call and return strobes save and restore only the two bank-enable flags. Software may rewrite the level directly, but only while the master enable is off.

The status word is laid out as bit 7 memory-bank enable, bit 6 register-bank enable, bits 5:4 nesting level, bit 3 carry, bits 2:0 skip flags. Vector byte `i` sits at bits `8*i+7 : 8*i` of `vec_tbl_i`.

Top module: `nist_ctrl`

## Requirements
- R1: After reset the level is 00, both bank-enable flags are 0, the pending flags are clear and `ack_o`, `push_o`, `rest_vld_o` are 0.
- R2: A source is eligible only when its pending flag, its enable bit and `mst_en_i` are all 1; at level 00 any eligible source is taken, at level 01 only one whose `irq_hi_i` bit is 1, and at level 10 none.
- R3: Among eligible sources the lowest index is taken; one cycle after the edge that sees it eligible, `ack_o` and `push_o` pulse high for one cycle, `ack_idx_o` holds its index and its pending flag is cleared so it is not taken again.
- R4: On a take, `push_word_o` carries the status word as it stood before the take (bank enables, old level, `cy_i`, `sk_i`), and the level rises by exactly one.
- R5: On a take, memory-bank enable is loaded from bit 7 and register-bank enable from bit 6 of the taken source's vector byte.
- R6: A `ret_i` strobe reloads the level (bits 5:4) and both bank-enable flags (bits 7:6) from `ret_word_i`, and for one cycle raises `rest_vld_o` with `rest_cy_o` = bit 3 and `rest_sk_o` = bits 2:0; a saved level of 11 is not loaded and the level is kept.
- R7: In a cycle with `ret_i`, `sret_i` or `call_i` high no source is taken; the take, if still eligible, happens one cycle later.
- R8: `call_i` pushes a word holding only the two bank-enable flags in bits 7:6 with all other bits 0 and leaves the level unchanged; `sret_i` reloads only the bank-enable flags from bits 7:6 of `ret_word_i`.
- R9: `sw_wr_i` loads `sw_lvl_i` into the level only while `mst_en_i` is 0; it has no effect while `mst_en_i` is 1, and a value of 11 is never loaded.
- R10: The level never holds the prohibited code 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | NUM_SRC | Request pulses, one per source |
| irq_en_i | input | NUM_SRC | Per-source enable bits |
| irq_hi_i | input | NUM_SRC | Per-source high-priority attribute |
| mst_en_i | input | 1 | Master interrupt enable |
| vec_tbl_i | input | 8*NUM_SRC | First vector byte of every source |
| cy_i | input | 1 | Current carry flag from the core |
| sk_i | input | 3 | Current skip flags from the core |
| ret_i | input | 1 | Return-from-interrupt strobe |
| sret_i | input | 1 | Subroutine return strobe |
| call_i | input | 1 | Subroutine call strobe |
| ret_word_i | input | 8 | Status word popped from the stack |
| sw_wr_i | input | 1 | Software write of the nesting level |
| sw_lvl_i | input | 2 | Level value for a software write |
| ack_o | output | 1 | One-cycle take pulse |
| ack_idx_o | output | IDX_W | Index of the taken source |
| ist_o | output | 2 | Current nesting level |
| mbe_o | output | 1 | Memory-bank enable flag |
| rbe_o | output | 1 | Register-bank enable flag |
| push_o | output | 1 | Stack push strobe |
| push_word_o | output | 8 | Word to push |
| rest_vld_o | output | 1 | Restore outputs valid |
| rest_cy_o | output | 1 | Restored carry flag |
| rest_sk_o | output | 3 | Restored skip flags |

## Verification
Every result is registered once: a request pulse sets the pending flag at one edge, the take is decided from that flag at the next edge, and `ack_o`, `push_word_o`, the new level and the new bank flags all appear together after that second edge; a return, call or software write shows its effect after the single edge that samples it. The bench drives inputs on the falling edge and samples on the following falling edge, so each check lands exactly one clock after the edge that should produce the result. The cycle after a take is checked too, to confirm the pulse ends and the cleared source is not taken twice, and the cycle of a return is checked to confirm the delayed take.

// File: rtl/nist_pkg.sv
package nist_pkg;

   localparam int unsigned WORD_W = 8;

   localparam logic [1:0] LVL_OPEN   = 2'b00;
   localparam logic [1:0] LVL_HIONLY = 2'b01;
   localparam logic [1:0] LVL_MASKED = 2'b10;
   localparam logic [1:0] LVL_BAD    = 2'b11;

   typedef struct packed {
      logic       mbe;
      logic       rbe;
      logic [1:0] lvl;
      logic       cy;
      logic [2:0] sk;
   } stat_word_t;

   function automatic logic lvl_legal(input logic [1:0] v);
      return v != LVL_BAD;
   endfunction

endpackage

// File: rtl/nist_arb.sv
module nist_arb
   import nist_pkg::*;
#(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] req_i,
   input  logic [NUM_SRC-1:0] en_i,
   input  logic [NUM_SRC-1:0] hi_i,
   input  logic [1:0]         lvl_i,
   input  logic               allow_i,
   output logic               take_o,
   output logic [IDX_W-1:0]   idx_o
);

   logic [NUM_SRC-1:0] pend_q;
   logic [NUM_SRC-1:0] elig;
   logic [NUM_SRC-1:0] grant;
   logic [NUM_SRC-1:0] lvl_mask;

   always_comb begin
      unique case (lvl_i)
         LVL_OPEN:   lvl_mask = '1;
         LVL_HIONLY: lvl_mask = hi_i;
         default:    lvl_mask = '0;
      endcase
   end

   assign elig = pend_q & en_i & lvl_mask & {NUM_SRC{allow_i}};

   always_comb begin
      grant = '0;
      idx_o = '0;
      for (int k = NUM_SRC - 1; k >= 0; k--) begin
         if (elig[k]) begin
            grant = '0;
            grant[k] = 1'b1;
            idx_o = IDX_W'(k);
         end
      end
   end

   assign take_o = |grant;

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_pend
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pend_q[g] <= 1'b0;
         else if (req_i[g])
            pend_q[g] <= 1'b1;
         else if (grant[g])
            pend_q[g] <= 1'b0;
      end
   end

   // R3
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R3
   grant_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !req_i[idx_o]) |=> !pend_q[$past(idx_o)]);

   // R2
   masked_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_i == LVL_MASKED) |-> !take_o);

endmodule

// File: rtl/nist_lvl.sv
module nist_lvl
   import nist_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ld_i,
   input  logic [1:0] ld_val_i,
   input  logic       inc_i,
   input  logic       wr_i,
   input  logic [1:0] wr_val_i,
   output logic [1:0] lvl_o
);

   logic [1:0] lvl_q;
   logic [1:0] lvl_d;

   always_comb begin
      lvl_d = lvl_q;
      if (ld_i) begin
         if (lvl_legal(ld_val_i))
            lvl_d = ld_val_i;
      end else if (inc_i) begin
         if (lvl_q != LVL_MASKED)
            lvl_d = lvl_q + 2'd1;
      end else if (wr_i) begin
         if (lvl_legal(wr_val_i))
            lvl_d = wr_val_i;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         lvl_q <= LVL_OPEN;
      else
         lvl_q <= lvl_d;
   end

   assign lvl_o = lvl_q;

   // R10
   no_bad_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q != LVL_BAD);

   // R9
   bad_write_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && !ld_i && !inc_i && wr_val_i == LVL_BAD) |=> $stable(lvl_q));

endmodule

// File: rtl/nist_ctrl.sv
module nist_ctrl
   import nist_pkg::*;
#(
   parameter int unsigned NUM_SRC = 6,
   parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_SRC-1:0]   irq_req_i,
   input  logic [NUM_SRC-1:0]   irq_en_i,
   input  logic [NUM_SRC-1:0]   irq_hi_i,
   input  logic                 mst_en_i,
   input  logic [8*NUM_SRC-1:0] vec_tbl_i,
   input  logic                 cy_i,
   input  logic [2:0]           sk_i,
   input  logic                 ret_i,
   input  logic                 sret_i,
   input  logic                 call_i,
   input  logic [7:0]           ret_word_i,
   input  logic                 sw_wr_i,
   input  logic [1:0]           sw_lvl_i,
   output logic                 ack_o,
   output logic [IDX_W-1:0]     ack_idx_o,
   output logic [1:0]           ist_o,
   output logic                 mbe_o,
   output logic                 rbe_o,
   output logic                 push_o,
   output logic [7:0]           push_word_o,
   output logic                 rest_vld_o,
   output logic                 rest_cy_o,
   output logic [2:0]           rest_sk_o
);

   localparam int unsigned VEC_W = 8 * NUM_SRC;

   if (NUM_SRC < 1 || NUM_SRC > 16) begin : g_bad_num
      $error("nist_ctrl: NUM_SRC must be 1..16");
   end
   if ((1 << IDX_W) < NUM_SRC) begin : g_bad_idx
      $error("nist_ctrl: IDX_W too narrow for NUM_SRC");
   end

   logic             busy;
   logic             take;
   logic [IDX_W-1:0] take_idx;
   logic [1:0]       lvl;
   logic [7:0]       vec_byte;
   logic             mbe_q;
   logic             rbe_q;
   stat_word_t       cur_word;
   stat_word_t       ret_word;

   assign busy     = ret_i | sret_i | call_i;
   assign ret_word = stat_word_t'(ret_word_i);

   nist_arb #(
      .NUM_SRC (NUM_SRC),
      .IDX_W   (IDX_W)
   ) arb_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (irq_req_i),
      .en_i    (irq_en_i),
      .hi_i    (irq_hi_i),
      .lvl_i   (lvl),
      .allow_i (mst_en_i & ~busy),
      .take_o  (take),
      .idx_o   (take_idx)
   );

   nist_lvl lvl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ld_i     (ret_i),
      .ld_val_i (ret_word.lvl),
      .inc_i    (take),
      .wr_i     (sw_wr_i & ~mst_en_i),
      .wr_val_i (sw_lvl_i),
      .lvl_o    (lvl)
   );

   always_comb begin
      vec_byte = '0;
      for (int k = 0; k < NUM_SRC; k++) begin
         if (take_idx == IDX_W'(k))
            vec_byte = vec_tbl_i[8*k +: 8];
      end
   end

   always_comb begin
      cur_word.mbe = mbe_q;
      cur_word.rbe = rbe_q;
      cur_word.lvl = lvl;
      cur_word.cy  = cy_i;
      cur_word.sk  = sk_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mbe_q <= 1'b0;
         rbe_q <= 1'b0;
      end else if (ret_i || sret_i) begin
         mbe_q <= ret_word.mbe;
         rbe_q <= ret_word.rbe;
      end else if (take) begin
         mbe_q <= vec_byte[7];
         rbe_q <= vec_byte[6];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_o       <= 1'b0;
         ack_idx_o   <= '0;
         push_o      <= 1'b0;
         push_word_o <= '0;
      end else begin
         ack_o  <= take;
         push_o <= take | (call_i & ~ret_i & ~sret_i);
         if (take) begin
            ack_idx_o   <= take_idx;
            push_word_o <= cur_word;
         end else if (call_i && !ret_i && !sret_i) begin
            push_word_o <= {mbe_q, rbe_q, 6'b0};
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rest_vld_o <= 1'b0;
         rest_cy_o  <= 1'b0;
         rest_sk_o  <= '0;
      end else begin
         rest_vld_o <= ret_i;
         if (ret_i) begin
            rest_cy_o <= ret_word.cy;
            rest_sk_o <= ret_word.sk;
         end
      end
   end

   assign ist_o = lvl;
   assign mbe_o = mbe_q;
   assign rbe_o = rbe_q;

   // R4
   ack_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> (ist_o == $past(ist_o) + 2'd1));

   // R2
   ack_not_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> ($past(ist_o) != LVL_MASKED));

   // R3
   ack_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_o |-> push_o);

   // R7
   busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !ack_o);

   // R9
   sw_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_wr_i && mst_en_i && !ret_i && !take) |=> $stable(ist_o));

   // R8
   call_keeps_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (call_i && !ret_i && !take && !sw_wr_i) |=> $stable(ist_o));

   // R6
   restore_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_i |=> rest_vld_o);

endmodule

// File: tb/nist_ctrl_tb.sv
module nist_ctrl_tb_top;

   localparam int N = 6;
   localparam int IW = 3;

   typedef struct packed {
      logic [1:0]   lvl;
      logic [N-1:0] req;
      logic [N-1:0] en;
      logic [N-1:0] hi;
      logic         ack;
      logic [IW-1:0] idx;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VT [NV] = '{
      '{2'd0, 6'b000110, 6'b111111, 6'b000000, 1'b1, 3'd1},
      '{2'd0, 6'b100000, 6'b011111, 6'b111111, 1'b0, 3'd0},
      '{2'd1, 6'b000011, 6'b111111, 6'b000010, 1'b1, 3'd1},
      '{2'd1, 6'b000011, 6'b111111, 6'b000000, 1'b0, 3'd0},
      '{2'd2, 6'b111111, 6'b111111, 6'b111111, 1'b0, 3'd0},
      '{2'd0, 6'b101000, 6'b111111, 6'b000000, 1'b1, 3'd3},
      '{2'd1, 6'b110000, 6'b111111, 6'b100000, 1'b1, 3'd5},
      '{2'd0, 6'b000000, 6'b111111, 6'b111111, 1'b0, 3'd0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N-1:0] irq_req = '0, irq_en = '0, irq_hi = '0;
   logic mst_en = 1'b0;
   logic [8*N-1:0] vec_tbl;
   logic cy = 1'b1;
   logic [2:0] sk = 3'b101;
   logic ret = 1'b0, sret = 1'b0, call = 1'b0;
   logic [7:0] ret_word = '0;
   logic sw_wr = 1'b0;
   logic [1:0] sw_lvl = '0;
   logic ack, mbe, rbe, push, rest_vld, rest_cy;
   logic [IW-1:0] ack_idx;
   logic [1:0] ist;
   logic [7:0] push_word;
   logic [2:0] rest_sk;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   for (genvar g = 0; g < N; g++) begin : g_vec
      assign vec_tbl[8*g +: 8] = {g[1:0], 6'(g)};
   end

   nist_ctrl #(.NUM_SRC(N), .IDX_W(IW)) dut_i (
      .clk(clk), .rst_n(rst_n), .irq_req_i(irq_req), .irq_en_i(irq_en),
      .irq_hi_i(irq_hi), .mst_en_i(mst_en), .vec_tbl_i(vec_tbl), .cy_i(cy),
      .sk_i(sk), .ret_i(ret), .sret_i(sret), .call_i(call),
      .ret_word_i(ret_word), .sw_wr_i(sw_wr), .sw_lvl_i(sw_lvl),
      .ack_o(ack), .ack_idx_o(ack_idx), .ist_o(ist), .mbe_o(mbe),
      .rbe_o(rbe), .push_o(push), .push_word_o(push_word),
      .rest_vld_o(rest_vld), .rest_cy_o(rest_cy), .rest_sk_o(rest_sk)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      irq_req = '0; mst_en = 1'b0; ret = 1'b0; sret = 1'b0; call = 1'b0; sw_wr = 1'b0;
      tick;
      rst_n = 1'b1;
      tick;
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 ist", ist, 0);
      chk("R1 ack", ack, 0);
      chk("R1 push", push, 0);
      chk("R1 rest_vld", rest_vld, 0);
      chk("R1 banks", {mbe, rbe}, 0);

      // R2 R3 R4 R5 vector walk
      for (int v = 0; v < NV; v++) begin
         do_reset();
         sw_lvl = VT[v].lvl; sw_wr = 1'b1;
         tick;
         sw_wr = 1'b0; irq_req = VT[v].req;
         tick;
         irq_req = '0; irq_en = VT[v].en; irq_hi = VT[v].hi; mst_en = 1'b1;
         tick;
         mst_en = 1'b0;
         chk("R2 ack", ack, VT[v].ack);
         if (VT[v].ack) begin
            chk("R3 idx", ack_idx, VT[v].idx);
            chk("R4 level step", ist, VT[v].lvl + 2'd1);
            chk("R4 push word", push_word, {2'b00, VT[v].lvl, 1'b1, 3'b101});
            chk("R5 banks", {mbe, rbe}, VT[v].idx[1:0]);
         end else begin
            chk("R2 level kept", ist, VT[v].lvl);
         end
      end

      // nesting sequence
      do_reset();
      irq_en = '1; irq_hi = 6'b000100;
      irq_req = 6'b000001;
      tick;
      irq_req = '0; mst_en = 1'b1;
      tick;
      chk("R3 first take", {ack, ack_idx}, {1'b1, 3'd0});
      chk("R4 level 01", ist, 1);
      tick;
      chk("R3 no retake", ack, 0);
      irq_req = 6'b001100;
      tick;
      irq_req = '0;
      tick;
      chk("R2 high at 01", {ack, ack_idx}, {1'b1, 3'd2});
      chk("R4 level 10", ist, 2);
      chk("R4 nested push", push_word, 8'h1D);
      chk("R5 banks idx2", {mbe, rbe}, 2'b10);
      tick;
      chk("R2 none at 10", ack, 0);
      chk("R10 level held", ist, 2);
      ret = 1'b1; ret_word = 8'h1D;
      tick;
      ret = 1'b0;
      chk("R6 level back", ist, 1);
      chk("R6 banks back", {mbe, rbe}, 0);
      chk("R6 restore", {rest_vld, rest_cy, rest_sk}, {1'b1, 1'b1, 3'b101});
      chk("R2 low blocked at 01", ack, 0);
      ret = 1'b1; ret_word = 8'h0D;
      tick;
      ret = 1'b0;
      chk("R7 take held off", ack, 0);
      chk("R6 level 00", ist, 0);
      tick;
      chk("R7 delayed take", {ack, ack_idx}, {1'b1, 3'd3});
      chk("R5 banks idx3", {mbe, rbe}, 2'b11);
      mst_en = 1'b0;
      ret = 1'b1; ret_word = 8'h30;
      tick;
      ret = 1'b0;
      chk("R6 bad level kept", ist, 1);
      chk("R6 banks from bad word", {mbe, rbe}, 0);

      // R9 software writes
      mst_en = 1'b1; sw_wr = 1'b1; sw_lvl = 2'd0;
      tick;
      sw_wr = 1'b0; mst_en = 1'b0;
      chk("R9 write locked", ist, 1);
      sw_wr = 1'b1; sw_lvl = 2'd3;
      tick;
      chk("R9 write 11 ignored", ist, 1);
      sw_lvl = 2'd0;
      tick;
      sw_wr = 1'b0;
      chk("R9 write applied", ist, 0);

      // R8 subroutine save/restore
      sret = 1'b1; ret_word = 8'hE5;
      tick;
      sret = 1'b0;
      chk("R8 sret banks", {mbe, rbe}, 2'b11);
      chk("R8 sret level", ist, 0);
      chk("R8 sret no restore", rest_vld, 0);
      call = 1'b1;
      tick;
      call = 1'b0;
      chk("R8 call push", {push, push_word}, {1'b1, 8'hC0});
      chk("R8 call level", ist, 0);
      chk("R8 call no ack", ack, 0);

      finish_run();
   end

endmodule